// File: doc/BRIEF.md
# Byte-Serial Descriptor CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a byte stream that protects command descriptors. Bytes arrive one per clock over a valid/ready handshake. A loadable start value seeds each computation; a fresh computation is seeded with all ones. The register shifts MSB-first using the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1. It applies no bit reflection and no output inversion, so the result matches neither the Ethernet nor the Castagnoli variant.

The running value is visible on `crc_o` after every accepted byte. When the producer flags the final byte, a one-cycle `done_o` pulse marks `crc_o` as the finished result. An optional comparator raises `match_o` in that same cycle when the result equals an expected value. All eight shift steps of a byte are evaluated combinationally in one cycle, without a lookup table.

The engine never applies back-pressure. `in_ready_o` is low only while reset is asserted and in the first clock after it. From then on it stays high, and a byte transfers on every clock edge where `in_valid_i` and `in_ready_o` are both high. A producer may therefore stream without gaps, and may hold `in_valid_i` low for any number of cycles.

Top module: `crc32d_engine`

## Requirements
- R1: A byte transferred with no `init_i` sets the register, at that edge, to the following value: XOR the byte into bits 31:24, then apply eight steps. Each step shifts left by one and XORs in 0x20044009 when bit 31 was 1 before the shift.
- R2: `in_ready_o` is 0 during reset and in the first cycle after its release, then stays 1. A byte transfers on each edge where `in_valid_i` and `in_ready_o` are both 1, which allows one byte per clock.
- R3: On an edge with neither `init_i` nor a transfer, `crc_o` keeps its value.
- R4: `init_i` loads `init_value_i` into the register at the next edge. A byte presented in the same cycle is consumed, has no effect on the register, and raises no `done_o`.
- R5: While `rst_n` is low, `crc_o` is 0xFFFFFFFF and `done_o` and `match_o` are 0.
- R6: `done_o` is 1 for exactly the cycle after a transfer with `in_last_i` = 1 and no `init_i`. In that cycle `crc_o` includes the last byte.
- R7: No final XOR or reversal is applied: starting from 0xFFFFFFFF, the bytes 0x01, 0x02, 0x03, 0x04 give 0xF33CB7D3 on `crc_o`.
- R8: `match_o` is 1 only in a `done_o` cycle. It is 1 exactly when the finished value equals `expect_i` as sampled with the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load start value (beats a same-cycle byte) |
| init_value_i | input | 32 | Start value for a new computation |
| in_valid_i | input | 1 | Byte valid |
| in_ready_o | output | 1 | Engine ready to take a byte |
| in_data_i | input | 8 | Byte to fold in |
| in_last_i | input | 1 | Marks the final byte of a descriptor |
| expect_i | input | 32 | Value compared with the finished result |
| crc_o | output | 32 | Running CRC register |
| done_o | output | 1 | One-cycle pulse: `crc_o` is final |
| match_o | output | 1 | Finished result equals `expect_i` |

## Verification
Each result of the block is due one clock after the edge that causes it:
- `crc_o` reflects a byte or an init load in the cycle after the edge that took it.
- `done_o` and `match_o` rise in the cycle after the last byte transfers.
- `in_ready_o` rises one cycle after reset is released.

The bench drives each stimulus on a falling edge and checks every output on the next falling edge, so each check lands exactly one register stage after its cause. Its reference model advances only on the cycles in which the handshake completes.

// File: rtl/crc32d_pkg.sv
package crc32d_pkg;
  localparam int          CRC_W       = 32;
  localparam int          BYTE_W      = 8;
  localparam logic [31:0] POLY_DEF    = 32'h2004_4009;
  localparam logic [31:0] SEED_DEF    = 32'hFFFF_FFFF;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc32d_step.sv
// Combinational fold of one input word into the CRC: BYTE_W shift stages.
module crc32d_step #(
  parameter int             CRC_W  = 32,
  parameter int             BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h2004_4009
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int PAD_W = CRC_W - BYTE_W;

  logic [CRC_W-1:0] stage [0:BYTE_W];

  assign stage[0] = crc_i ^ {data_i, {PAD_W{1'b0}}};

  for (genvar k = 0; k < BYTE_W; k++) begin : g_shift
    assign stage[k+1] = stage[k][CRC_W-1] ? ((stage[k] << 1) ^ POLY)
                                          : (stage[k] << 1);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/crc32d_cmp.sv
module crc32d_cmp #(
  parameter int CRC_W = 32
) (
  input  logic [CRC_W-1:0] a_i,
  input  logic [CRC_W-1:0] b_i,
  output logic             eq_o
);
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/crc32d_core.sv
// State, handshake and completion flags.
module crc32d_core #(
  parameter int               CRC_W    = 32,
  parameter int               BYTE_W   = 8,
  parameter logic [CRC_W-1:0] RST_VAL  = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [CRC_W-1:0]  init_value_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [CRC_W-1:0]  crc_next_i,
  input  logic              hit_i,
  output logic [CRC_W-1:0]  crc_q_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              match_o
);
  logic             ready_q;
  logic             done_q;
  logic             match_q;
  logic [CRC_W-1:0] crc_q;
  logic             take;
  logic             finish;

  assign take   = in_valid_i & ready_q & ~init_i;
  assign finish = take & in_last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= RST_VAL;
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= finish;
      match_q <= finish & hit_i;
      if (init_i)    crc_q <= init_value_i;
      else if (take) crc_q <= crc_next_i;
    end
  end

  assign crc_q_o = crc_q;
  assign ready_o = ready_q;
  assign done_o  = done_q;
  assign match_o = match_q;

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !(in_valid_i && ready_q)) |=> $stable(crc_q)); // R3
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (crc_q == $past(init_value_i))); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && ready_q && in_last_i && !init_i) |=> done_q); // R6
  AST_NO_DONE_ON_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !done_q); // R4
  AST_MATCH_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> done_q); // R8
endmodule

// File: rtl/crc32d_engine.sv
module crc32d_engine #(
  parameter int          BYTE_W   = crc32d_pkg::BYTE_W,
  parameter logic [31:0] POLY     = crc32d_pkg::POLY_DEF,
  parameter logic [31:0] RST_VAL  = crc32d_pkg::SEED_DEF,
  parameter bit          MATCH_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic [31:0]       init_value_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [31:0]       expect_i,
  output logic [31:0]       crc_o,
  output logic              done_o,
  output logic              match_o
);
  localparam int W = crc32d_pkg::CRC_W;

  crc32d_pkg::crc_t crc_q;
  crc32d_pkg::crc_t crc_next;
  logic             hit;

  crc32d_step #(.CRC_W(W), .BYTE_W(BYTE_W), .POLY(POLY)) u_step (
    .crc_i  (crc_q),
    .data_i (in_data_i),
    .crc_o  (crc_next)
  );

  if (MATCH_EN) begin : g_match
    crc32d_cmp #(.CRC_W(W)) u_cmp (
      .a_i  (crc_next),
      .b_i  (expect_i),
      .eq_o (hit)
    );
  end else begin : g_nomatch
    assign hit = 1'b0;
  end

  crc32d_core #(.CRC_W(W), .BYTE_W(BYTE_W), .RST_VAL(RST_VAL)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .init_value_i (init_value_i),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .crc_next_i   (crc_next),
    .hit_i        (hit),
    .crc_q_o      (crc_q),
    .ready_o      (in_ready_o),
    .done_o       (done_o),
    .match_o      (match_o)
  );

  assign crc_o = crc_q;
endmodule

// File: tb/crc32d_engine_tb_top.sv
`timescale 1ns/1ps
module crc32d_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic [31:0] init_value_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = '0;
  logic        in_last_i = 1'b0;
  logic [31:0] expect_i = '0;
  logic [31:0] crc_o;
  logic        done_o;
  logic        match_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] model = 32'hFFFF_FFFF;

  always #10 clk = ~clk;

  crc32d_engine dut_i (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .init_value_i(init_value_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .expect_i(expect_i), .crc_o(crc_o),
    .done_o(done_o), .match_o(match_o)
  );

  // Table-style reference: remainder of (top byte ^ data) after 8 shifts.
  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] t;
    t = {c[31:24] ^ b, 24'h0};
    for (int i = 0; i < 8; i++)
      t = t[31] ? ((t << 1) ^ 32'h2004_4009) : (t << 1);
    return (c << 8) ^ t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle on a falling edge; check outputs on the next falling edge.
  task automatic cyc(input bit ini, input logic [31:0] iv, input bit v,
                     input logic [7:0] d, input bit l, input logic [31:0] ex,
                     input string req);
    bit ed, em;
    init_i = ini; init_value_i = iv; in_valid_i = v;
    in_data_i = d; in_last_i = l; expect_i = ex;
    @(negedge clk);
    if (ini)    model = iv;
    else if (v) model = ref_byte(model, d);
    ed = v && !ini && l;
    em = ed && (model == ex);
    chk(req, crc_o, model);
    chk(req, {31'b0, done_o}, {31'b0, ed});
    chk(req, {31'b0, match_o}, {31'b0, em});
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R5: reset values
    chk("R5", crc_o, 32'hFFFF_FFFF);
    chk("R5", {31'b0, done_o}, 32'd0);
    chk("R5", {31'b0, match_o}, 32'd0);
    chk("R2", {31'b0, in_ready_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", {31'b0, in_ready_o}, 32'd1);

    // R7 / R8: known vector with matching expected value
    cyc(1, 32'hFFFF_FFFF, 0, 8'h00, 0, 0, "R4");
    cyc(0, 0, 1, 8'h01, 0, 32'hF33C_B7D3, "R1");
    cyc(0, 0, 1, 8'h02, 0, 32'hF33C_B7D3, "R1");
    cyc(0, 0, 1, 8'h03, 0, 32'hF33C_B7D3, "R1");
    cyc(0, 0, 1, 8'h04, 1, 32'hF33C_B7D3, "R8");
    chk("R7", crc_o, 32'hF33C_B7D3);
    chk("R8", {31'b0, match_o}, 32'd1);
    chk("R6", {31'b0, done_o}, 32'd1);

    // R3: idle cycles keep the value, done falls
    cyc(0, 0, 0, 8'hAA, 1, 0, "R3");
    cyc(0, 0, 0, 8'h55, 0, 0, "R3");

    // R4: init beats a same-cycle last byte
    cyc(1, 32'h1234_5678, 1, 8'h9C, 1, 32'h1234_5678, "R4");
    chk("R4", crc_o, 32'h1234_5678);

    // R8: mismatch on expected value
    cyc(0, 0, 1, 8'h00, 1, 32'h0, "R8");
    cyc(1, 32'h0, 0, 0, 0, 0, "R4");
    cyc(0, 0, 1, 8'h00, 1, 32'h0, "R1");  // zero in, zero out

    // R1/R2/R6/R8: random back-to-back traffic
    for (int k = 0; k < 4000; k++) begin
      bit          ini, v, l;
      logic [7:0]  d;
      logic [31:0] iv, ex;
      ini = ($urandom % 16) == 0;
      v   = ($urandom % 4) != 0;
      l   = ($urandom % 8) == 0;
      d   = 8'($urandom);
      iv  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      ex  = ($urandom % 2 == 0) ? ref_byte(model, d) : $urandom;
      cyc(ini, iv, v, d, l, ex, "R1");
      chk("R2", {31'b0, in_ready_o}, 32'd1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule